// File: doc/BRIEF.md
# Byte/Word Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small 16-bit processor. Each cycle it takes an operation code, a byte/word select, a destination operand, a source operand and the current negative, zero and carry flags. One cycle later it presents the result, a write strobe telling the register file whether to store that result, and the new flags. It covers moves, add and subtract with and without carry, compare, a non-storing AND test, the bitwise operations, increment and decrement, single-bit shifts, rotates through carry, counted arithmetic shifts and rotates, sign extension and duplication of the low byte, and forcing the carry.

The block has no sequencing of its own. Its only state is the output register, which holds the last result and flags. The "state" advances on every clock edge from the inputs present at that edge. Reset is asynchronous and active low. There are no other states or transitions.

Top module: `bwalu`

## Requirements
- R1: Operation codes on `op_i`: 0 MOV, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 CMP, 6 TST, 7 AND, 8 OR, 9 XOR, 10 NOT, 11 INC, 12 DEC, 13 ASR, 14 LSL, 15 LSR, 16 RCL, 17 RCR, 18 SXB, 19 DUB, 20 ASH, 21 ROT, 22 SEC, 23 CLC. The inputs are sampled on a rising edge, and the outputs show the answer from that edge onward. While `rst_n` is low, `result_o`, `wr_o` and `flags_o` are all zero. Flags are packed as bit 2 = N, bit 1 = Z and bit 0 = C.
- R2: ADD gives dst+src and ADC gives dst+src+C. C is the carry out of the operand's top bit, Z is set when the result is zero, and N is the result's top bit.
- R3: SUB gives dst-src and SBC gives dst-src-C. In both, C is set when a borrow occurs. CMP sets the flags exactly as SUB does, but drives `wr_o` low and returns dst unchanged on `result_o`.
- R4: When `byte_i` is 1 and the code is 0 to 12, only the low 8 bits take part. C comes from bit 8 (carry or borrow), N from bit 7 and Z from the low byte. The upper byte of `result_o` equals the upper byte of dst. For codes 13 and above, `byte_i` has no effect.
- R5: MOV (result src), AND, OR, XOR and NOT (result ~dst) clear C and set Z and N from the result. TST sets its flags from dst AND src, clears C, drives `wr_o` low and returns dst.
- R6: INC gives dst+1 and DEC gives dst-1. Both leave C at its input value and set Z and N from the result.
- R7: ASR shifts right and keeps bit 15. LSR shifts right and fills with 0. LSL shifts left and fills with 0. In all three, C receives the bit shifted out.
- R8: RCL gives {dst[14:0],C} and takes the new C from dst[15]. RCR gives {C,dst[15:1]} and takes the new C from dst[0].
- R9: SXB copies dst[7] into bits 15..8 and keeps the low byte. DUB copies dst[7:0] into both bytes. Both clear C.
- R10: ASH reads src[4:0] as a signed count k. If k>0, dst is shifted left k places. If k<0, dst is shifted right arithmetically by -k places, up to 16. C receives the last bit shifted out. If k=0, the result is dst and C is 0.
- R11: ROT reads the same signed count. Positive values rotate left and negative values rotate right. After a left rotate C equals result bit 0, and after a right rotate C equals result bit 15. If k=0, the result is dst and C is 0.
- R12: SEC forces C to 1 and CLC forces C to 0. Both keep N and Z and drive `wr_o` low. Codes 24 to 31 drive `wr_o` low and pass all flags through. Whenever `wr_o` is low, `result_o` equals dst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| byte_i | input | 1 | 1 selects byte operation |
| dst_i | input | 16 | Destination operand (also the shifted register) |
| src_i | input | 16 | Source operand or shift count |
| flags_i | input | 3 | Incoming N, Z, C |
| result_o | output | 16 | Registered result |
| wr_o | output | 1 | Result should be written back |
| flags_o | output | 3 | Registered updated N, Z, C |

## Verification
The output register is the only state, so any internal error appears on `result_o`, `wr_o` or `flags_o` on the first edge after the offending inputs, and the next edge overwrites it. A wrong carry mux or byte merge shows up only for certain operand values, such as a carry out of bit 7 versus bit 15, borrows at zero, or counts of 0, -16 and 15. For that reason the bench sweeps every code in both widths over operands chosen to sit on those edges, and it sweeps every shift count separately.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

    typedef enum logic [4:0] {
        OP_MOV = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
        OP_SBC = 5'd4,  OP_CMP = 5'd5,  OP_TST = 5'd6,  OP_AND = 5'd7,
        OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_NOT = 5'd10, OP_INC = 5'd11,
        OP_DEC = 5'd12, OP_ASR = 5'd13, OP_LSL = 5'd14, OP_LSR = 5'd15,
        OP_RCL = 5'd16, OP_RCR = 5'd17, OP_SXB = 5'd18, OP_DUB = 5'd19,
        OP_ASH = 5'd20, OP_ROT = 5'd21, OP_SEC = 5'd22, OP_CLC = 5'd23
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/bwalu_addsub.sv
module bwalu_addsub #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cy_word_o,
    output logic             cy_byte_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] ext_w;
    logic [HALF:0]  ext_b;

    always_comb begin
        if (sub_i) begin
            ext_w = {1'b0, a_i} - {1'b0, b_i} - {{WIDTH{1'b0}}, cin_i};
            ext_b = {1'b0, a_i[HALF-1:0]} - {1'b0, b_i[HALF-1:0]} - {{HALF{1'b0}}, cin_i};
        end else begin
            ext_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
            ext_b = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
        end
    end

    assign sum_o     = ext_w[WIDTH-1:0];
    assign cy_word_o = ext_w[WIDTH];
    assign cy_byte_o = ext_b[HALF];

endmodule

// File: rtl/bwalu_shift.sv
module bwalu_shift #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             rotate_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cy_o
);
    localparam logic [CNT_W:0] WIDTH_V = (CNT_W+1)'(WIDTH);

    logic             neg;
    logic             zero;
    logic [CNT_W:0]   mag;
    logic [CNT_W-2:0] rot_amt;
    logic [2*WIDTH-1:0] dbl;
    logic [WIDTH-1:0] probe;

    always_comb begin
        neg     = cnt_i[CNT_W-1];
        zero    = (cnt_i == '0);
        mag     = neg ? ({1'b0, ~cnt_i} + 1'b1) : {1'b0, cnt_i};
        rot_amt = cnt_i[CNT_W-2:0];
        dbl     = {a_i, a_i} << rot_amt;
        probe   = '0;
        if (rotate_i) begin
            res_o = dbl[2*WIDTH-1:WIDTH];
            cy_o  = zero ? 1'b0 : (neg ? res_o[WIDTH-1] : res_o[0]);
        end else if (zero) begin
            res_o = a_i;
            cy_o  = 1'b0;
        end else if (!neg) begin
            res_o = a_i << mag;
            probe = a_i >> (WIDTH_V - mag);
            cy_o  = probe[0];
        end else begin
            res_o = WIDTH'($signed(a_i) >>> mag);
            probe = a_i >> (mag - 1'b1);
            cy_o  = probe[0];
        end
    end

endmodule

// File: rtl/bwalu.sv
module bwalu
    import bwalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       op_i,
    input  logic             byte_i,
    input  logic [WIDTH-1:0] dst_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [2:0]       flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_o,
    output logic [2:0]       flags_o
);
    localparam int HALF  = WIDTH / 2;
    localparam int CNT_W = $clog2(WIDTH) + 1;

    alu_op_e    op;
    alu_flags_t fin;
    alu_flags_t fnext;
    logic       byte_mode;

    logic [WIDTH-1:0] as_b, as_sum, sh_res;
    logic             as_cin, as_sub, as_cyw, as_cyb, sh_cy;

    logic [WIDTH-1:0] raw, merged, res_next;
    logic             c_next, wr_next, keep_zn;

    assign op        = alu_op_e'(op_i);
    assign fin       = alu_flags_t'(flags_i);
    assign byte_mode = byte_i && (op_i <= OP_DEC);

    assign as_b   = (op == OP_INC || op == OP_DEC) ? WIDTH'(1) : src_i;
    assign as_cin = (op == OP_ADC || op == OP_SBC) ? fin.c : 1'b0;
    assign as_sub = (op == OP_SUB || op == OP_SBC || op == OP_CMP || op == OP_DEC);

    bwalu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .a_i      (dst_i),
        .b_i      (as_b),
        .cin_i    (as_cin),
        .sub_i    (as_sub),
        .sum_o    (as_sum),
        .cy_word_o(as_cyw),
        .cy_byte_o(as_cyb)
    );

    bwalu_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_shift (
        .a_i     (dst_i),
        .cnt_i   (src_i[CNT_W-1:0]),
        .rotate_i(op == OP_ROT),
        .res_o   (sh_res),
        .cy_o    (sh_cy)
    );

    // Operation decode: raw result, carry, write strobe.
    always_comb begin
        raw     = dst_i;
        c_next  = fin.c;
        wr_next = 1'b1;
        keep_zn = 1'b0;
        unique case (op)
            OP_MOV: begin raw = src_i;          c_next = 1'b0; end
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                raw    = as_sum;
                c_next = byte_mode ? as_cyb : as_cyw;
            end
            OP_CMP: begin
                raw     = as_sum;
                c_next  = byte_mode ? as_cyb : as_cyw;
                wr_next = 1'b0;
            end
            OP_TST: begin raw = dst_i & src_i;  c_next = 1'b0; wr_next = 1'b0; end
            OP_AND: begin raw = dst_i & src_i;  c_next = 1'b0; end
            OP_OR:  begin raw = dst_i | src_i;  c_next = 1'b0; end
            OP_XOR: begin raw = dst_i ^ src_i;  c_next = 1'b0; end
            OP_NOT: begin raw = ~dst_i;         c_next = 1'b0; end
            OP_INC, OP_DEC: raw = as_sum;
            OP_ASR: begin raw = {dst_i[WIDTH-1], dst_i[WIDTH-1:1]}; c_next = dst_i[0]; end
            OP_LSL: begin raw = {dst_i[WIDTH-2:0], 1'b0};          c_next = dst_i[WIDTH-1]; end
            OP_LSR: begin raw = {1'b0, dst_i[WIDTH-1:1]};          c_next = dst_i[0]; end
            OP_RCL: begin raw = {dst_i[WIDTH-2:0], fin.c};         c_next = dst_i[WIDTH-1]; end
            OP_RCR: begin raw = {fin.c, dst_i[WIDTH-1:1]};         c_next = dst_i[0]; end
            OP_SXB: begin raw = {{(WIDTH-HALF){dst_i[HALF-1]}}, dst_i[HALF-1:0]}; c_next = 1'b0; end
            OP_DUB: begin raw = {dst_i[HALF-1:0], dst_i[HALF-1:0]}; c_next = 1'b0; end
            OP_ASH, OP_ROT: begin raw = sh_res; c_next = sh_cy; end
            OP_SEC: begin c_next = 1'b1; wr_next = 1'b0; keep_zn = 1'b1; end
            OP_CLC: begin c_next = 1'b0; wr_next = 1'b0; keep_zn = 1'b1; end
            default: begin wr_next = 1'b0; keep_zn = 1'b1; end
        endcase
    end

    // Width merge and flag formation.
    always_comb begin
        merged   = byte_mode ? {dst_i[WIDTH-1:HALF], raw[HALF-1:0]} : raw;
        res_next = wr_next ? merged : dst_i;
        fnext.c  = c_next;
        if (keep_zn) begin
            fnext.z = fin.z;
            fnext.n = fin.n;
        end else if (byte_mode) begin
            fnext.z = (raw[HALF-1:0] == '0);
            fnext.n = raw[HALF-1];
        end else begin
            fnext.z = (raw == '0);
            fnext.n = raw[WIDTH-1];
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_o     <= 1'b0;
            flags_o  <= '0;
        end else begin
            result_o <= res_next;
            wr_o     <= wr_next;
            flags_o  <= fnext;
        end
    end

endmodule

// File: rtl/bwalu_chk.sv
module bwalu_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       op_i,
    input logic             byte_i,
    input logic [WIDTH-1:0] dst_i,
    input logic [WIDTH-1:0] src_i,
    input logic [2:0]       flags_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_o,
    input logic [2:0]       flags_o
);
    localparam int HALF = WIDTH / 2;

    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd5) |=> (!wr_o && result_o == $past(dst_i)));

    a_r5_tst_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd6) |=> (!wr_o && !flags_o[0] && result_o == $past(dst_i)));

    a_r5_logic_clears_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd0 || (op_i >= 5'd7 && op_i <= 5'd10)) |=> (wr_o && !flags_o[0]));

    a_r6_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd11 || op_i == 5'd12) |=> (flags_o[0] == $past(flags_i[0])));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_i && op_i <= 5'd12) |=> (result_o[WIDTH-1:HALF] == $past(dst_i[WIDTH-1:HALF])));

    a_r9_sxb_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd18) |=> (result_o[HALF-1:0] == $past(dst_i[HALF-1:0])
                             && result_o[WIDTH-1] == $past(dst_i[HALF-1]) && !flags_o[0]));

    a_r12_sec_only_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd22) |=> (!wr_o && flags_o == {$past(flags_i[2:1]), 1'b1}));

    a_r12_clc_only_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd23) |=> (!wr_o && flags_o == {$past(flags_i[2:1]), 1'b0}));

    a_r12_unused_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 5'd24) |=> (!wr_o && flags_o == $past(flags_i) && result_o == $past(dst_i)));

endmodule

bind bwalu bwalu_chk #(.WIDTH(WIDTH)) i_bwalu_chk (.*);

// File: tb/test_bwalu.sv
module test_bwalu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [15:0] dst_i = '0;
    logic [15:0] src_i = '0;
    logic [2:0]  flags_i = '0;
    logic [15:0] result_o;
    logic        wr_o;
    logic [2:0]  flags_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bwalu i_bwalu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i),
        .dst_i(dst_i), .src_i(src_i), .flags_i(flags_i),
        .result_o(result_o), .wr_o(wr_o), .flags_o(flags_o)
    );

    logic [15:0] pats [12] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                               16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3, 16'h0013, 16'hFF00};
    logic [2:0] fpats [4] = '{3'b000, 3'b001, 3'b110, 3'b111};

    // Expected {wr, result, N, Z, C} from the requirements.
    function automatic logic [19:0] model(input logic [4:0] op, input logic bsel,
                                          input logic [15:0] d, input logic [15:0] s,
                                          input logic [2:0] f);
        logic bm = bsel && (op <= 5'd12);
        int wid = bm ? 8 : 16;
        logic [15:0] dv = bm ? {8'h00, d[7:0]} : d;
        logic [15:0] sv = bm ? {8'h00, s[7:0]} : s;
        logic [16:0] x = {1'b0, d};
        logic c = f[0];
        logic z, n, wr = 1'b1, pass = 1'b0;
        logic [15:0] res;
        int k;
        case (op)
            5'd0:  begin x = {1'b0, sv}; c = 1'b0; end
            5'd1:  begin x = dv + sv; c = x[wid]; end
            5'd2:  begin x = dv + sv + f[0]; c = x[wid]; end
            5'd3:  begin x = dv - sv; c = x[wid]; end
            5'd4:  begin x = dv - sv - f[0]; c = x[wid]; end
            5'd5:  begin x = dv - sv; c = x[wid]; wr = 1'b0; end
            5'd6:  begin x = {1'b0, dv & sv}; c = 1'b0; wr = 1'b0; end
            5'd7:  begin x = {1'b0, dv & sv}; c = 1'b0; end
            5'd8:  begin x = {1'b0, dv | sv}; c = 1'b0; end
            5'd9:  begin x = {1'b0, dv ^ sv}; c = 1'b0; end
            5'd10: begin x = {1'b0, ~dv}; c = 1'b0; end
            5'd11: x = dv + 1;
            5'd12: x = dv - 1;
            5'd13: begin x = {1'b0, d[15], d[15:1]}; c = d[0]; end
            5'd14: begin x = {1'b0, d[14:0], 1'b0}; c = d[15]; end
            5'd15: begin x = {2'b00, d[15:1]}; c = d[0]; end
            5'd16: begin x = {1'b0, d[14:0], f[0]}; c = d[15]; end
            5'd17: begin x = {1'b0, f[0], d[15:1]}; c = d[0]; end
            5'd18: begin x = {1'b0, {8{d[7]}}, d[7:0]}; c = 1'b0; end
            5'd19: begin x = {1'b0, d[7:0], d[7:0]}; c = 1'b0; end
            5'd20, 5'd21: begin
                k = $signed(s[4:0]);
                c = 1'b0;
                for (int i = 0; i < k; i++) begin
                    if (op == 5'd20) begin c = x[15]; x = {1'b0, x[14:0], 1'b0}; end
                    else             begin x = {1'b0, x[14:0], x[15]}; c = x[0]; end
                end
                for (int i = 0; i < -k; i++) begin
                    if (op == 5'd20) begin c = x[0]; x = {1'b0, x[15], x[15:1]}; end
                    else             begin x = {1'b0, x[0], x[15:1]}; c = x[15]; end
                end
            end
            5'd22: begin c = 1'b1; wr = 1'b0; pass = 1'b1; end
            5'd23: begin c = 1'b0; wr = 1'b0; pass = 1'b1; end
            default: begin wr = 1'b0; pass = 1'b1; end
        endcase
        if (bm) begin
            res = {d[15:8], x[7:0]}; z = (x[7:0] == 8'h00); n = x[7];
        end else begin
            res = x[15:0]; z = (x[15:0] == 16'h0000); n = x[15];
        end
        if (pass) begin z = f[1]; n = f[2]; end
        if (!wr) res = d;
        return {wr, res, n, z, c};
    endfunction

    function automatic string tag(input logic [4:0] op, input logic bsel);
        if (bsel && op <= 5'd12) return "R4";
        case (op)
            5'd1, 5'd2:                 return "R2";
            5'd3, 5'd4, 5'd5:           return "R3";
            5'd0, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10: return "R5";
            5'd11, 5'd12:               return "R6";
            5'd13, 5'd14, 5'd15:        return "R7";
            5'd16, 5'd17:               return "R8";
            5'd18, 5'd19:               return "R9";
            5'd20:                      return "R10";
            5'd21:                      return "R11";
            default:                    return "R12";
        endcase
    endfunction

    // Apply on a falling edge, captured on the next rising edge, sampled on the following falling edge.
    task automatic run(input logic [4:0] op, input logic bsel, input logic [15:0] d,
                       input logic [15:0] s, input logic [2:0] f);
        logic [19:0] exp;
        @(negedge clk);
        op_i = op; byte_i = bsel; dst_i = d; src_i = s; flags_i = f;
        exp = model(op, bsel, d, s, f);
        @(negedge clk);
        tests++;
        if ({wr_o, result_o, flags_o} !== exp) begin
            fails++;
            $display("FAIL %s op=%0d byte=%0d dst=%h src=%h flags=%b: got wr=%b res=%h f=%b, expected wr=%b res=%h f=%b",
                     tag(op, bsel), op, bsel, d, s, f, wr_o, result_o, flags_o,
                     exp[19], exp[18:3], exp[2:0]);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        tests++;
        if ({wr_o, result_o, flags_o} !== 20'h0) begin
            fails++;
            $display("FAIL R1 reset: got wr=%b res=%h f=%b, expected 0 0 0", wr_o, result_o, flags_o);
        end
        rst_n = 1'b1;
        // R1..R12: every code, both widths, edge operands, flag patterns
        for (int op = 0; op < 32; op++)
            for (int b = 0; b < 2; b++)
                for (int fi = 0; fi < 4; fi++)
                    for (int di = 0; di < 12; di++)
                        for (int si = 0; si < 12; si++)
                            run(op[4:0], b[0], pats[di], pats[si], fpats[fi]);
        // R10, R11: every count value
        for (int op = 20; op < 22; op++)
            for (int di = 0; di < 12; di++)
                for (int cnt = 0; cnt < 32; cnt++)
                    for (int b = 0; b < 2; b++)
                        run(op[4:0], b[0], pats[di], 16'(cnt), 3'b001);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule